// File: doc/BRIEF.md
# Loop Instruction Buffer

This block is a very small instruction store placed between the fetch stage and the instruction cache. It records every instruction that returns from the cache, together with its word address, in a circular window of consecutive addresses that always holds the most recent eight. Recording is continuous and does not wait for a loop to be detected. A short loop is therefore already held in full when its closing branch is taken for the first time.

Each taken-branch redirect is compared against the address range the window currently holds. On a hit the block enters a serving mode. In that mode the redirect target and the sequential fetches after it are read from the local store, and no cache access is made. The first sequential fetch beyond the newest held address leaves serving mode and goes to the cache again. Its response extends the window, so a loop body plus branch that is too long for eight entries simply falls back to normal fetch. A redirect whose response does not continue the window restarts the window at the new address. A flush input empties the window in one cycle.

The cache is expected to answer every request in the following cycle. Buffer hits are given the same one-cycle latency, so the consumer sees one uniform output stream. Addresses are word addresses.

Top module: `loop_ibuf`

## Requirements
- R1: After reset, `out_valid_o` and `out_from_buf_o` are 0 and the window is empty, so the first redirect is sent to the cache.
- R2: A request that is not served from the buffer raises `cache_req_o` in the same cycle with `cache_addr_o` equal to the request address. In the next cycle the cache response appears on `out_instr_o` with `out_valid_o`=1 and `out_from_buf_o`=0.
- R3: Each cache response whose address is one past the newest held address is appended to the window. The eight most recent consecutive addresses, with their instructions, are kept.
- R4: A redirect whose target is held does not raise `cache_req_o`. In the next cycle `out_instr_o` carries the instruction originally returned for that address, with `out_from_buf_o`=1. Only a redirect can enter serving mode: a plain fetch made outside serving mode always goes to the cache, even when its address is held.
- R5: In serving mode, every plain fetch to a held address is served from the buffer, with no cache request and `out_from_buf_o`=1 in the next cycle.
- R6: In serving mode, a fetch to an address that is not held leaves serving mode and goes to the cache. When that address is one past the newest entry, its response is appended.
- R7: At most eight entries are held. Appending to a full window drops the oldest address, so a branch back across nine or more instructions misses.
- R8: A cache response whose address does not continue the window (including one to an address already held) replaces the whole window with that single entry.
- R9: `flush_i` empties the window in one cycle and ends serving mode. A request made in the flush cycle goes to the cache, and its response starts the new window.
- R10: When `redir_valid_i` and `fetch_req_i` are both high, the request uses `redir_target_i` and `fetch_addr_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Invalidate all held entries |
| fetch_req_i | input | 1 | Sequential fetch request |
| fetch_addr_i | input | AW (32) | Word address of the sequential fetch |
| redir_valid_i | input | 1 | Taken-branch redirect, which is itself a fetch request |
| redir_target_i | input | AW (32) | Redirect target word address |
| cache_req_o | output | 1 | Instruction cache access request |
| cache_addr_o | output | AW (32) | Instruction cache access address |
| cache_rsp_valid_i | input | 1 | Cache response valid, one cycle after the request |
| cache_rsp_data_i | input | DW (32) | Cache response instruction |
| out_valid_o | output | 1 | Instruction delivered to fetch |
| out_instr_o | output | DW (32) | Delivered instruction |
| out_from_buf_o | output | 1 | 1 when the delivered instruction came from the buffer |

## Verification
The assertions check the window bookkeeping on every cycle. They confirm that the count never exceeds eight, that an append either grows the count by one or keeps it full, that a non-continuing capture leaves exactly one entry at the new address, and that flush leaves the window empty. They also confirm that serving mode is entered only through a redirect and is left on a miss or a flush. Whether the data served from the buffer is the instruction the cache originally returned for that address can only be shown by the bench's scenarios. The same holds for loops of exactly eight against nine instructions, for the restart after a far branch, and for redirect priority. In each case the bench compares the delivered stream against a cache model and a model of the address window.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic {
    SRC_CACHE = 1'b0,
    SRC_BUF   = 1'b1
  } src_e;
endpackage

// File: rtl/lb_rst_sync.sv
module lb_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/lb_window.sv
// Tracks which consecutive word addresses the store currently holds.
module lb_window #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          look_hit_o,
  output logic [PW-1:0] look_slot_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic [PW-1:0] wr_slot_o
);
  logic [AW-1:0] base_q, base_d;
  logic [PW-1:0] head_q, head_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] look_off, tail_addr;
  logic          is_seq, full, upd_en;

  always_comb begin
    look_off    = look_addr_i - base_q;
    look_hit_o  = (cnt_q != '0) && (look_off < AW'(cnt_q));
    look_slot_o = head_q + look_off[PW-1:0];
    tail_addr   = base_q + AW'(cnt_q);
    is_seq      = (cnt_q != '0) && (wr_addr_i == tail_addr);
    full        = (cnt_q == CW'(DEPTH));
    wr_slot_o   = is_seq ? (head_q + cnt_q[PW-1:0]) : '0;
  end

  always_comb begin
    base_d = base_q;
    head_d = head_q;
    cnt_d  = cnt_q;
    upd_en = flush_i | wr_en_i;
    if (flush_i) begin
      cnt_d  = '0;
      head_d = '0;
    end else if (wr_en_i) begin
      if (is_seq) begin
        if (full) begin
          base_d = base_q + AW'(1);
          head_d = head_q + PW'(1);
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        base_d = wr_addr_i;
        head_d = '0;
        cnt_d  = CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> cnt_q == '0);

  p_append_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush_i) && $past(wr_en_i) && $past(is_seq) |->
      cnt_q == ($past(full) ? $past(cnt_q) : $past(cnt_q) + CW'(1)));

  p_restart_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i && !flush_i && !is_seq) |->
      (cnt_q == CW'(1)) && (base_q == $past(wr_addr_i)));
endmodule

// File: rtl/lb_store.sv
// Instruction storage with a registered read port.
module lb_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_slot_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] rd_slot_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en_i && (wr_slot_i == PW'(e));
    always_ff @(posedge clk) begin
      if (ent_we) mem_q[e] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= mem_q[rd_slot_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/lb_ctrl.sv
// Serving mode, pending cache access and output source selection.
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          redir_valid_i,
  input  logic [AW-1:0] redir_target_i,
  input  logic          win_hit_i,
  input  logic          cache_rsp_valid_i,
  output logic [AW-1:0] eff_addr_o,
  output logic          use_buf_o,
  output logic          cache_req_o,
  output logic          cap_en_o,
  output logic [AW-1:0] cap_addr_o,
  output logic          rsp_fwd_o,
  output src_e          src_o
);
  logic          serve_q, serve_d;
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  src_e          src_q, src_d;
  logic          eff_req;

  always_comb begin
    eff_req     = redir_valid_i | fetch_req_i;
    eff_addr_o  = redir_valid_i ? redir_target_i : fetch_addr_i;
    use_buf_o   = eff_req && !flush_i && win_hit_i && (redir_valid_i || serve_q);
    cache_req_o = eff_req && !use_buf_o;
    serve_d     = serve_q;
    if (flush_i)      serve_d = 1'b0;
    else if (eff_req) serve_d = use_buf_o;
    src_d       = use_buf_o ? SRC_BUF : SRC_CACHE;
    rsp_fwd_o   = pend_q && cache_rsp_valid_i;
    cap_en_o    = rsp_fwd_o && !flush_i;
    cap_addr_o  = pend_addr_q;
    src_o       = src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serve_q <= 1'b0;
      pend_q  <= 1'b0;
      src_q   <= SRC_CACHE;
    end else begin
      serve_q <= serve_d;
      pend_q  <= cache_req_o;
      src_q   <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend_addr_q <= '0;
    else if (cache_req_o) pend_addr_q <= eff_addr_o;
  end

  p_enter_by_redir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_BUF) && !$past(serve_q) |-> $past(redir_valid_i));

  p_leave_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serve_q && fetch_req_i && !redir_valid_i && !flush_i && !win_hit_i |=> !serve_q);

  p_flush_ends_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !serve_q);
endmodule

// File: rtl/loop_ibuf.sv
module loop_ibuf
  import lb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          redir_valid_i,
  input  logic [AW-1:0] redir_target_i,
  output logic          cache_req_o,
  output logic [AW-1:0] cache_addr_o,
  input  logic          cache_rsp_valid_i,
  input  logic [DW-1:0] cache_rsp_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_instr_o,
  output logic          out_from_buf_o
);
  logic          rst_n_s;
  logic [AW-1:0] eff_addr, cap_addr;
  logic          win_hit, use_buf, cap_en, rsp_fwd;
  logic [PW-1:0] look_slot, wr_slot;
  logic [DW-1:0] rd_data;
  src_e          src;

  lb_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  lb_ctrl #(.AW(AW)) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n_s),
    .flush_i           (flush_i),
    .fetch_req_i       (fetch_req_i),
    .fetch_addr_i      (fetch_addr_i),
    .redir_valid_i     (redir_valid_i),
    .redir_target_i    (redir_target_i),
    .win_hit_i         (win_hit),
    .cache_rsp_valid_i (cache_rsp_valid_i),
    .eff_addr_o        (eff_addr),
    .use_buf_o         (use_buf),
    .cache_req_o       (cache_req_o),
    .cap_en_o          (cap_en),
    .cap_addr_o        (cap_addr),
    .rsp_fwd_o         (rsp_fwd),
    .src_o             (src)
  );

  lb_window #(.AW(AW), .DEPTH(DEPTH)) u_win (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .flush_i     (flush_i),
    .look_addr_i (eff_addr),
    .look_hit_o  (win_hit),
    .look_slot_o (look_slot),
    .wr_en_i     (cap_en),
    .wr_addr_i   (cap_addr),
    .wr_slot_o   (wr_slot)
  );

  lb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en_i   (cap_en),
    .wr_slot_i (wr_slot),
    .wr_data_i (cache_rsp_data_i),
    .rd_en_i   (use_buf),
    .rd_slot_i (look_slot),
    .rd_data_o (rd_data)
  );

  assign cache_addr_o   = eff_addr;
  assign out_from_buf_o = (src == SRC_BUF);
  assign out_valid_o    = out_from_buf_o | rsp_fwd;
  assign out_instr_o    = out_from_buf_o ? rd_data : cache_rsp_data_i;

  p_buf_skips_cache_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_from_buf_o |-> $past(!cache_req_o && (fetch_req_i || redir_valid_i)));
endmodule

// File: tb/loop_ibuf_test.sv
module loop_ibuf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, fetch_req_i, redir_valid_i;
  logic [31:0] fetch_addr_i, redir_target_i;
  logic        cache_req_o;
  logic [31:0] cache_addr_o;
  logic        rsp_v;
  logic [31:0] rsp_d;
  logic        out_valid_o, out_from_buf_o;
  logic [31:0] out_instr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  loop_ibuf uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i),
    .redir_valid_i(redir_valid_i), .redir_target_i(redir_target_i),
    .cache_req_o(cache_req_o), .cache_addr_o(cache_addr_o),
    .cache_rsp_valid_i(rsp_v), .cache_rsp_data_i(rsp_d),
    .out_valid_o(out_valid_o), .out_instr_o(out_instr_o),
    .out_from_buf_o(out_from_buf_o)
  );

  function automatic logic [31:0] code_of(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  // cache model: answers every request in the next cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v <= 1'b0;
      rsp_d <= '0;
    end else begin
      rsp_v <= cache_req_o;
      rsp_d <= code_of(cache_addr_o);
    end
  end

  // window model from the requirements
  logic [31:0] m_base;
  int          m_cnt;
  bit          m_serve, m_pend;
  logic [31:0] m_paddr;
  bit          e_valid, e_buf;
  logic [31:0] e_data;
  string       e_tag;
  bit          last_hit;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_out();
    chk(out_valid_o == e_valid, e_tag, "out_valid", 32'(out_valid_o), 32'(e_valid));
    if (e_valid) begin
      chk(out_from_buf_o == e_buf, e_tag, "from_buf", 32'(out_from_buf_o), 32'(e_buf));
      chk(out_instr_o == e_data, e_tag, "instr", out_instr_o, e_data);
    end
  endtask

  task automatic step(input bit req, input logic [31:0] fa, input bit rd,
                      input logic [31:0] ta, input bit fl, input string tag);
    logic [31:0] eff, off;
    bit eq, hit;
    @(negedge clk);
    check_out();
    fetch_req_i = req; fetch_addr_i = fa;
    redir_valid_i = rd; redir_target_i = ta; flush_i = fl;
    #1;
    eq  = req | rd;
    eff = rd ? ta : fa;
    off = eff - m_base;
    hit = eq && !fl && (m_cnt != 0) && (off < 32'(m_cnt)) && (rd || m_serve);
    last_hit = hit;
    chk(cache_req_o == (eq && !hit), tag, "cache_req", 32'(cache_req_o), 32'(eq && !hit));
    if (eq && !hit) chk(cache_addr_o == eff, tag, "cache_addr", cache_addr_o, eff);
    e_valid = eq; e_buf = hit; e_data = code_of(eff); e_tag = tag;
    if (fl) m_serve = 0; else if (eq) m_serve = hit;
    if (m_pend && !fl) begin
      if (m_cnt != 0 && m_paddr == m_base + 32'(m_cnt)) begin
        if (m_cnt == 8) m_base = m_base + 1; else m_cnt++;
      end else begin
        m_base = m_paddr; m_cnt = 1;
      end
    end
    if (fl) m_cnt = 0;
    m_pend = eq && !hit; m_paddr = eff;
  endtask

  task automatic fetch(input logic [31:0] a, input string tag);
    step(1, a, 0, 32'hx, 0, tag);
  endtask
  task automatic redir(input logic [31:0] a, input string tag);
    step(0, 32'h0, 1, a, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 32'h0, 0, 32'h0, 0, tag);
  endtask
  task automatic expect_hit(input bit h, input string tag);
    chk(last_hit == h, tag, "model hit", 32'(last_hit), 32'(h));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] nxt;
    void'($urandom(32'd20240611));
    rst_n = 0; flush_i = 0; fetch_req_i = 0; redir_valid_i = 0;
    fetch_addr_i = 0; redir_target_i = 0;
    m_base = 0; m_cnt = 0; m_serve = 0; m_pend = 0; m_paddr = 0;
    e_valid = 0; e_buf = 0; e_data = 0; e_tag = "R1";
    repeat (4) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    chk(out_valid_o == 0, "R1", "out_valid", 32'(out_valid_o), 0);
    chk(out_from_buf_o == 0, "R1", "from_buf", 32'(out_from_buf_o), 0);
    redir(32'd100, "R1");
    chk(cache_req_o == 1, "R1", "empty redirect to cache", 32'(cache_req_o), 1);
    // R2/R3: sequential fill 101..107 (100 already fetched)
    for (int i = 101; i < 108; i++) fetch(32'(i), "R2");
    idle("R3");
    // R4: loop of eight hits on first backward branch
    redir(32'd100, "R4"); expect_hit(1, "R4");
    // R5: remaining body served from buffer
    for (int i = 101; i < 108; i++) fetch(32'(i), "R5");
    // R6: past newest leaves and appends 108
    fetch(32'd108, "R6"); expect_hit(0, "R6");
    idle("R6");
    redir(32'd108, "R6"); expect_hit(1, "R6");
    // R7: window now 101..108; 100 has been dropped
    redir(32'd101, "R7"); expect_hit(1, "R7");
    redir(32'd100, "R7"); expect_hit(0, "R7");
    idle("R8");
    // R8: window restarted at 100 only
    redir(32'd101, "R8"); expect_hit(0, "R8");
    idle("R8");
    // R4: plain fetch to held address outside serving mode goes to cache
    fetch(32'd101, "R4"); expect_hit(0, "R4");
    idle("R4");
    // R8: response to already-held 101 restarted window at {101}
    redir(32'd100, "R8"); expect_hit(0, "R8");
    // R9: fill, flush, then redirect misses
    for (int i = 200; i < 206; i++) fetch(32'(i), "R9");
    idle("R9");
    step(0, 32'h0, 1, 32'd202, 1, "R9"); expect_hit(0, "R9");
    idle("R9");
    redir(32'd203, "R9"); expect_hit(0, "R9");
    idle("R9");
    redir(32'd202, "R9"); expect_hit(1, "R9");
    // R10: redirect overrides fetch address
    step(1, 32'd999, 1, 32'd202, 0, "R10"); expect_hit(1, "R10");
    step(1, 32'd202, 1, 32'd777, 0, "R10"); expect_hit(0, "R10");
    idle("R10");
    // random loops, far jumps, flushes
    nxt = 32'd500;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 7) begin
        logic [31:0] t;
        t = nxt - 32'(1 + $urandom % 11);
        step($urandom % 2 == 0, $urandom, 1, t, 0, "R5");
        nxt = t + 1;
      end else if (r < 9) begin
        logic [31:0] t;
        t = 32'($urandom % 4096);
        redir(t, "R8");
        nxt = t + 1;
      end else if (r < 10) begin
        step(1, nxt, 0, 32'h0, 1, "R9");
        nxt = nxt + 1;
      end else if (r < 14) begin
        idle("R3");
      end else begin
        fetch(nxt, "R6");
        nxt = nxt + 1;
      end
    end
    idle("R2");
    idle("R2");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule